// File: doc/BRIEF.md
# Ring Prefetch Controller

The block streams data out of a circular region of external memory into a small local word FIFO, and a downstream bit reader pops words from that FIFO. The region runs from a start address, which is always rounded down to an 8-byte boundary, to an end address. Reads go out as bursts of up to a fixed number of 8-byte words over a plain request/grant/response port. On the consuming side the block keeps a byte-granular read pointer, a count of bytes available to the reader, and a counter of how many times that pointer has wrapped from the end of the region back to its start.

Software loads a byte pointer with an init pulse, then turns on fetching and draining. Fetching can be gated in two ways. It can follow a plain enable, or it can also be held back by a producer's write position (level mode), so that the block never reads past data not yet written. A restart follows a fixed order: drop both enables, wait for busy to go low, pulse init. The start address may change on the fly, and the new value applies at the next wrap. An optional byte reversal can be applied to each word as it leaves the FIFO.

Top module: `ring_prefetch_ctrl`

## Requirements
- R1: After reset or an init pulse, busy, mem_req and rd_ready are low, bytes_avail and wrap_count are 0, and curr_ptr equals the loaded byte address (0 after reset). Reset alone starts no fetch.
- R2: Burst addresses are 8-byte aligned. The first burst after init starts at the loaded pointer with its low three bits cleared, and each later burst starts right after the previous one. Each burst is 1 to BURST_WORDS (4) words long and never reads past the word that holds cfg_end. A burst that ends on that word is followed by one at cfg_start rounded down to 8 bytes.
- R3: A burst is requested only when the FIFO has room for a full BURST_WORDS burst. With draining off, the FIFO fills to exactly FIFO_DEPTH (16) words and fetching stops, so busy is low and bytes_avail is 128 minus the low three bits of curr_ptr.
- R4: Words are delivered in address order. rd_ready is high only when draining is enabled and the FIFO holds a word. rd_pop while rd_ready is low has no effect.
- R5: curr_ptr is the byte address of the next byte to hand out. After each pop it becomes the next aligned word address, or the aligned start address if that word would lie past cfg_end. bytes_avail equals 8 times the FIFO word count minus curr_ptr[2:0].
- R6: wrap_count rises by one each time curr_ptr wraps from the end of the region to the start.
- R7: With level mode off and cfg_fill_en low, no new burst is requested. A burst already granted finishes, and busy stays high until its last beat.
- R8: In level mode, fetching stops before the word that holds cfg_level, so delivery stops after the last word below it. Fetching resumes when cfg_level moves forward.
- R9: With cfg_swap set, rd_data is the head word with its 8 bytes in reverse order (byte 0 exchanged with byte 7, and so on).
- R10: A new cfg_start takes effect at the next wrap of both the fetch and the read pointers, with no init pulse.
- R11: After the restart sequence (both enables off, busy low, init pulse), delivery restarts from the newly loaded pointer with an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 32 | Region start byte address (low 3 bits ignored) |
| cfg_end | input | 32 | Region end byte address (last word = cfg_end rounded down to 8) |
| cfg_curr | input | 32 | Byte pointer loaded by init |
| cfg_level | input | 32 | Producer write position used in level mode |
| cfg_init | input | 1 | Init: reloads pointers, clears FIFO and wrap counter |
| cfg_fill_en | input | 1 | Enables memory fetching |
| cfg_drain_en | input | 1 | Enables delivery to the reader |
| cfg_use_level | input | 1 | Also gate fetching by cfg_level |
| cfg_swap | input | 1 | Reverse byte order of output words |
| mem_req | output | 1 | Burst request, held until granted |
| mem_addr | output | 32 | Burst start address (8-byte aligned) |
| mem_len | output | 3 | Burst length in words |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Response beat valid |
| mem_rdata | input | 64 | Response beat data |
| rd_pop | input | 1 | Reader pops the head word |
| rd_ready | output | 1 | Head word available |
| rd_data | output | 64 | Head word, optionally byte-reversed |
| curr_ptr | output | 32 | Byte address of next byte to deliver |
| bytes_avail | output | 8 | Bytes available to the reader |
| wrap_count | output | 16 | Read-pointer wrap counter |
| busy | output | 1 | A burst is requested or in flight |

## Verification
The properties assume that the environment pulses cfg_init only while busy is low and both enables are off. They also assume that cfg_end lies at or above every pointer in use, that the memory returns exactly mem_len beats per grant, and that cfg_start is never moved above a pointer that has not yet wrapped. The bench keeps within these limits. Its restart phase drops the enables and waits for busy to fall before init. It moves the start address only downward and only while the fetch pointer is still short of the end. Its responder returns beats one per cycle after a short, varying delay, and checks each burst's address and length against an address counter of its own.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned OFS_W      = 3;
    localparam int unsigned WORD_W     = WORD_BYTES * 8;

    typedef enum logic [1:0] {
        FETCH_IDLE,
        FETCH_REQ,
        FETCH_DATA
    } fetch_state_e;
endpackage

// File: rtl/rpf_store.sv
module rpf_store #(
    parameter int unsigned DW    = 64,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } store_t;

    store_t        s_d, s_q;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else begin
            if (push) s_d.wr = bump(s_q.wr);
            if (pop)  s_d.rd = bump(s_q.rd);
            case ({push, pop})
                2'b10:   s_d.cnt = s_q.cnt + CW'(1);
                2'b01:   s_d.cnt = s_q.cnt - CW'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[s_q.wr] <= push_data;
    end

    assign head  = mem[s_q.rd];
    assign count = s_q.cnt;
endmodule

// File: rtl/rpf_fetch.sv
module rpf_fetch
    import rpf_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned BURST = 4,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1),
    parameter int unsigned LW    = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [AW-1:0] init_addr,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic          fill_en,
    input  logic          use_level,
    input  logic [AW-1:0] level_addr,
    input  logic [CW-1:0] fifo_count,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    output logic          busy,
    output logic          beat_push
);
    typedef struct packed {
        fetch_state_e  st;
        logic [AW-1:0] fptr;
        logic [AW-1:0] raddr;
        logic [LW-1:0] rlen;
        logic [LW-1:0] left;
    } fetch_t;

    fetch_t        s_d, s_q;
    logic [AW-1:0] start_w, end_w, lvl_w;
    logic [AW-1:0] to_end, to_lvl, lim, nxt;
    logic [CW-1:0] free;
    logic          room, lvl_ok, go;

    always_comb begin
        s_d     = s_q;
        start_w = {start_addr[AW-1:OFS_W], OFS_W'(0)};
        end_w   = {end_addr[AW-1:OFS_W], OFS_W'(0)};
        lvl_w   = {level_addr[AW-1:OFS_W], OFS_W'(0)};
        to_end  = ((end_w - s_q.fptr) >> OFS_W) + AW'(1);
        to_lvl  = (lvl_w - s_q.fptr) >> OFS_W;
        lim     = AW'(BURST);
        if (to_end < lim) lim = to_end;
        if (use_level && (lvl_w > s_q.fptr) && (to_lvl < lim)) lim = to_lvl;
        free    = CW'(DEPTH) - fifo_count;
        room    = free >= CW'(BURST);
        lvl_ok  = !use_level || (lvl_w != s_q.fptr);
        go      = fill_en && lvl_ok && room && !init;
        nxt     = s_q.raddr + (AW'(s_q.rlen) << OFS_W);

        case (s_q.st)
            FETCH_IDLE: begin
                if (go) begin
                    s_d.st    = FETCH_REQ;
                    s_d.raddr = s_q.fptr;
                    s_d.rlen  = LW'(lim);
                end
            end
            FETCH_REQ: begin
                if (mem_gnt) begin
                    s_d.st   = FETCH_DATA;
                    s_d.left = s_q.rlen;
                    s_d.fptr = (nxt > end_w) ? start_w : nxt;
                end
            end
            FETCH_DATA: begin
                if (mem_rvalid) begin
                    s_d.left = s_q.left - LW'(1);
                    if (s_q.left == LW'(1)) s_d.st = FETCH_IDLE;
                end
            end
            default: s_d.st = FETCH_IDLE;
        endcase

        if (init) begin
            s_d.st   = FETCH_IDLE;
            s_d.fptr = {init_addr[AW-1:OFS_W], OFS_W'(0)};
            s_d.left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: FETCH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign mem_req   = (s_q.st == FETCH_REQ);
    assign mem_addr  = s_q.raddr;
    assign mem_len   = s_q.rlen;
    assign busy      = (s_q.st != FETCH_IDLE);
    assign beat_push = (s_q.st == FETCH_DATA) && mem_rvalid;
endmodule

// File: rtl/rpf_reader.sv
module rpf_reader
    import rpf_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned DW     = 64,
    parameter int unsigned CW     = 5,
    parameter int unsigned WRAP_W = 16,
    parameter int unsigned AVW    = CW + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [AW-1:0]     init_addr,
    input  logic [AW-1:0]     start_addr,
    input  logic [AW-1:0]     end_addr,
    input  logic              drain_en,
    input  logic              swap_en,
    input  logic              rd_pop,
    input  logic [CW-1:0]     fifo_count,
    input  logic [DW-1:0]     head,
    output logic              rd_ready,
    output logic [DW-1:0]     rd_data,
    output logic [AW-1:0]     curr_ptr,
    output logic [AVW-1:0]    bytes_avail,
    output logic [WRAP_W-1:0] wrap_count,
    output logic              pop_ok
);
    localparam int unsigned NBYTES = DW / 8;

    typedef struct packed {
        logic [AW-1:0]     curr;
        logic [WRAP_W-1:0] wraps;
    } rd_t;

    rd_t           s_d, s_q;
    logic [AW-1:0] start_w, end_w, nc;
    logic [DW-1:0] swapped;

    for (genvar i = 0; i < NBYTES; i++) begin : g_swap
        assign swapped[8*i +: 8] = head[DW-1-8*i -: 8];
    end

    assign rd_ready = drain_en && (fifo_count != '0) && !init;
    assign pop_ok   = rd_ready && rd_pop;

    always_comb begin
        s_d     = s_q;
        start_w = {start_addr[AW-1:OFS_W], OFS_W'(0)};
        end_w   = {end_addr[AW-1:OFS_W], OFS_W'(0)};
        nc      = {s_q.curr[AW-1:OFS_W], OFS_W'(0)} + AW'(WORD_BYTES);
        if (init) begin
            s_d.curr  = init_addr;
            s_d.wraps = '0;
        end else if (pop_ok) begin
            if (nc > end_w) begin
                s_d.curr  = start_w;
                s_d.wraps = s_q.wraps + WRAP_W'(1);
            end else begin
                s_d.curr  = nc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data     = swap_en ? swapped : head;
    assign curr_ptr    = s_q.curr;
    assign wrap_count  = s_q.wraps;
    assign bytes_avail = (fifo_count == '0) ? '0
                       : ({fifo_count, OFS_W'(0)} - AVW'(s_q.curr[OFS_W-1:0]));
endmodule

// File: rtl/ring_prefetch_ctrl.sv
module ring_prefetch_ctrl
    import rpf_pkg::*;
#(
    parameter  int unsigned ADDR_W      = 32,
    parameter  int unsigned FIFO_DEPTH  = 16,
    parameter  int unsigned BURST_WORDS = 4,
    parameter  int unsigned WRAP_W      = 16,
    localparam int unsigned DATA_W      = WORD_W,
    localparam int unsigned CNT_W       = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned LEN_W       = $clog2(BURST_WORDS + 1),
    localparam int unsigned AVAIL_W     = CNT_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_start,
    input  logic [ADDR_W-1:0]  cfg_end,
    input  logic [ADDR_W-1:0]  cfg_curr,
    input  logic [ADDR_W-1:0]  cfg_level,
    input  logic               cfg_init,
    input  logic               cfg_fill_en,
    input  logic               cfg_drain_en,
    input  logic               cfg_use_level,
    input  logic               cfg_swap,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               rd_pop,
    output logic               rd_ready,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  curr_ptr,
    output logic [AVAIL_W-1:0] bytes_avail,
    output logic [WRAP_W-1:0]  wrap_count,
    output logic               busy
);
    logic              beat_push;
    logic              pop_ok;
    logic [CNT_W-1:0]  fifo_count;
    logic [DATA_W-1:0] head;

    rpf_fetch #(
        .AW(ADDR_W), .BURST(BURST_WORDS), .DEPTH(FIFO_DEPTH),
        .CW(CNT_W), .LW(LEN_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .init(cfg_init), .init_addr(cfg_curr),
        .start_addr(cfg_start), .end_addr(cfg_end),
        .fill_en(cfg_fill_en), .use_level(cfg_use_level), .level_addr(cfg_level),
        .fifo_count(fifo_count),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .busy(busy), .beat_push(beat_push)
    );

    rpf_store #(
        .DW(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .clear(cfg_init),
        .push(beat_push), .push_data(mem_rdata),
        .pop(pop_ok),
        .head(head), .count(fifo_count)
    );

    rpf_reader #(
        .AW(ADDR_W), .DW(DATA_W), .CW(CNT_W), .WRAP_W(WRAP_W), .AVW(AVAIL_W)
    ) u_reader (
        .clk(clk), .rst_n(rst_n),
        .init(cfg_init), .init_addr(cfg_curr),
        .start_addr(cfg_start), .end_addr(cfg_end),
        .drain_en(cfg_drain_en), .swap_en(cfg_swap),
        .rd_pop(rd_pop), .fifo_count(fifo_count), .head(head),
        .rd_ready(rd_ready), .rd_data(rd_data),
        .curr_ptr(curr_ptr), .bytes_avail(bytes_avail),
        .wrap_count(wrap_count), .pop_ok(pop_ok)
    );
endmodule

// File: rtl/rpf_checker.sv
module rpf_checker #(
    parameter int unsigned AW     = 32,
    parameter int unsigned LW     = 3,
    parameter int unsigned BURST  = 4,
    parameter int unsigned WRAP_W = 16,
    parameter int unsigned AVW    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     cfg_end,
    input logic              cfg_init,
    input logic              cfg_fill_en,
    input logic              cfg_drain_en,
    input logic              cfg_use_level,
    input logic              mem_req,
    input logic [AW-1:0]     mem_addr,
    input logic [LW-1:0]     mem_len,
    input logic              mem_gnt,
    input logic              rd_ready,
    input logic [AVW-1:0]    bytes_avail,
    input logic [WRAP_W-1:0] wrap_count,
    input logic              busy
);
    logic [AW-1:0] last_byte;
    assign last_byte = {cfg_end[AW-1:3], 3'b111};

    // R2: a pending request holds its address and length until granted
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len));

    // R2: aligned bursts of legal length
    a_r2_burst_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000) && (mem_len != '0) && (mem_len <= LW'(BURST)));

    // R2: no burst reads past the last word of the region
    a_r2_end_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr + (AW'(mem_len) << 3) - AW'(1)) <= last_byte);

    // R3: a request is always counted as busy
    a_r3_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R4: nothing is offered to the reader while draining is off
    a_r4_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> cfg_drain_en);

    // R5: an offered word always carries at least one byte
    a_r5_avail_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> bytes_avail != '0);

    // R6: the wrap counter only steps by one outside init
    a_r6_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_init |=> (wrap_count == $past(wrap_count)) ||
                      (wrap_count == $past(wrap_count) + WRAP_W'(1)));

    // R1: init leaves cleared state
    a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_init |=> (wrap_count == '0) && (bytes_avail == '0) && !rd_ready && !mem_req);

    // R7: no new request once fetching is disabled and idle
    a_r7_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fill_en && !busy |=> !mem_req);
endmodule

bind ring_prefetch_ctrl rpf_checker #(
    .AW(ADDR_W), .LW(LEN_W), .BURST(BURST_WORDS), .WRAP_W(WRAP_W), .AVW(AVAIL_W)
) u_rpf_checker (
    .clk(clk), .rst_n(rst_n), .cfg_end(cfg_end), .cfg_init(cfg_init),
    .cfg_fill_en(cfg_fill_en), .cfg_drain_en(cfg_drain_en),
    .cfg_use_level(cfg_use_level),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
    .rd_ready(rd_ready), .bytes_avail(bytes_avail), .wrap_count(wrap_count),
    .busy(busy)
);

// File: tb/ring_prefetch_ctrl_bench.sv
`timescale 1ns/1ps
module ring_prefetch_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_start = '0, cfg_end = '0, cfg_curr = '0, cfg_level = '0;
    logic        cfg_init = 0, cfg_fill_en = 0, cfg_drain_en = 0;
    logic        cfg_use_level = 0, cfg_swap = 0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [2:0]  mem_len;
    logic        mem_gnt = 0, mem_rvalid = 0;
    logic [63:0] mem_rdata = '0;
    logic        rd_pop = 0;
    logic        rd_ready;
    logic [63:0] rd_data;
    logic [31:0] curr_ptr;
    logic [7:0]  bytes_avail;
    logic [15:0] wrap_count;
    logic        busy;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_next;
    logic [31:0] exp_fetch;
    int          exp_wraps = 0;
    bit          exp_swap = 0;
    bit          force_pop = 0;
    int          pace = 0;
    int          req_count = 0;

    always #5 clk = ~clk;

    ring_prefetch_ctrl u_ring_prefetch_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_curr(cfg_curr),
        .cfg_level(cfg_level), .cfg_init(cfg_init), .cfg_fill_en(cfg_fill_en),
        .cfg_drain_en(cfg_drain_en), .cfg_use_level(cfg_use_level), .cfg_swap(cfg_swap),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rd_pop(rd_pop), .rd_ready(rd_ready), .rd_data(rd_data),
        .curr_ptr(curr_ptr), .bytes_avail(bytes_avail),
        .wrap_count(wrap_count), .busy(busy)
    );

    function automatic logic [31:0] align8(input logic [31:0] a);
        return {a[31:3], 3'b000};
    endfunction

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a};
    endfunction

    function automatic logic [63:0] rev_bytes(input logic [63:0] w);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = w[63-8*i -: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // scoreboard driver: push expected byte addresses of delivered words
    task automatic push_stream(input int n);
        logic [31:0] nx;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp_next);
            nx = align8(exp_next) + 32'd8;
            if (nx > align8(cfg_end)) begin
                nx = align8(cfg_start);
                exp_wraps++;
            end
            exp_next = nx;
        end
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk);
        check("R4 stream drained", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic do_init(input logic [31:0] c);
        cfg_curr = c;
        cfg_init = 1;
        @(negedge clk);
        @(negedge clk);
        cfg_init  = 0;
        exp_fetch = align8(c);
        exp_next  = c;
        exp_wraps = 0;
        @(negedge clk);
    endtask

    // monitor: pops, compares head word and byte pointer with the scoreboard
    always @(negedge clk) begin
        logic [31:0] a;
        rd_pop = force_pop;
        if (!force_pop && rd_ready && exp_q.size() != 0 && (pace % 3) != 2) begin
            a = exp_q.pop_front();
            if (exp_swap) check("R9 swapped data", rd_data, rev_bytes(mem_word(align8(a))));
            else          check("R4 data order", rd_data, mem_word(align8(a)));
            check("R5 curr ptr", 64'(curr_ptr), 64'(a));
            rd_pop = 1;
        end
        pace++;
    end

    // memory responder with its own burst address tracking (R2)
    initial begin
        logic [31:0] a;
        logic [2:0]  l;
        int          nb;
        nb = 0;
        forever begin
            @(negedge clk);
            if (mem_req && rst_n) begin
                a = mem_addr;
                l = mem_len;
                req_count++;
                check("R2 burst addr", 64'(a), 64'(exp_fetch));
                n_tests++;
                if (l == 0 || l > 4 || (a + 32'(l) * 8 - 1) > {cfg_end[31:3], 3'b111}) begin
                    n_fail++;
                    $display("FAIL R2 burst len: actual %0d expected 1..4 within end", l);
                end
                exp_fetch = a + 32'(l) * 8;
                if (exp_fetch > align8(cfg_end)) exp_fetch = align8(cfg_start);
                mem_gnt = 1;
                @(negedge clk);
                mem_gnt = 0;
                repeat (1 + nb % 3) @(negedge clk);
                for (int i = 0; i < int'(l); i++) begin
                    mem_rvalid = 1;
                    mem_rdata  = mem_word(a + 32'(i) * 8);
                    @(negedge clk);
                end
                mem_rvalid = 0;
                nb++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int snap;
        int words;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset busy", 64'(busy), 0);
        check("R1 reset req", 64'(mem_req), 0);
        check("R1 reset ready", 64'(rd_ready), 0);
        check("R1 reset avail", 64'(bytes_avail), 0);
        check("R1 reset wraps", 64'(wrap_count), 0);

        // R3: fill to full with drain off, unaligned pointer
        cfg_start = 32'h0000_1003;
        cfg_end   = 32'h0000_11FF;
        do_init(32'h0000_1005);
        cfg_fill_en = 1;
        repeat (300) @(negedge clk);
        check("R3 full avail", 64'(bytes_avail), 64'd123);
        check("R3 idle when full", 64'(busy), 0);
        check("R4 ready off", 64'(rd_ready), 0);
        // R4: pops while not ready are ignored
        force_pop = 1;
        repeat (4) @(negedge clk);
        force_pop = 0;
        @(negedge clk);
        check("R4 ignored pop avail", 64'(bytes_avail), 64'd123);
        check("R4 ignored pop ptr", 64'(curr_ptr), 64'h1005);

        // R4 R5 R6: stream across one wrap
        push_stream(70);
        cfg_drain_en = 1;
        wait_drain();
        repeat (5) @(negedge clk);
        check("R6 wrap count", 64'(wrap_count), 64'(exp_wraps));

        // R9: byte reversal
        cfg_swap = 1;
        exp_swap = 1;
        push_stream(10);
        wait_drain();
        cfg_swap = 0;
        exp_swap = 0;

        // R10: move start lower without init; applies at next wrap
        cfg_start = 32'h0000_0F00;
        push_stream(56);
        wait_drain();
        repeat (5) @(negedge clk);
        check("R10 wrap count", 64'(wrap_count), 64'(exp_wraps));
        check("R10 new start ptr", 64'(curr_ptr), 64'(exp_next));

        // R7: fetch disabled
        cfg_fill_en = 0;
        wait_idle();
        @(negedge clk);
        snap  = req_count;
        words = int'(bytes_avail) / 8;
        push_stream(words);
        wait_drain();
        repeat (50) @(negedge clk);
        check("R7 no new bursts", 64'(req_count), 64'(snap));
        check("R7 ready low", 64'(rd_ready), 0);
        check("R7 avail empty", 64'(bytes_avail), 0);

        // R11: restart sequence
        cfg_drain_en = 0;
        wait_idle();
        do_init(32'h0000_0F13);
        check("R11 restart ptr", 64'(curr_ptr), 64'h0F13);
        check("R1 init wraps", 64'(wrap_count), 0);
        check("R1 init avail", 64'(bytes_avail), 0);
        check("R1 init busy", 64'(busy), 0);

        // R8: level mode
        cfg_use_level = 1;
        cfg_level     = 32'h0000_0F64;
        cfg_fill_en   = 1;
        cfg_drain_en  = 1;
        push_stream(10);
        wait_drain();
        repeat (100) @(negedge clk);
        check("R8 stop at level ready", 64'(rd_ready), 0);
        check("R8 stop at level busy", 64'(busy), 0);
        cfg_level = 32'h0000_0F90;
        push_stream(6);
        wait_drain();
        repeat (100) @(negedge clk);
        check("R8 resume then stop", 64'(rd_ready), 0);
        check("R8 resume ptr", 64'(curr_ptr), 64'h0F90);

        summary();
        $finish;
    end
endmodule